// File: doc/BRIEF.md
# Capture-Triggered One-Shot Pulse Timer

This block turns a rising edge on an asynchronous trigger input into exactly one output pulse. The pulse starts a programmable number of timer ticks after the trigger and stays high for a programmable number of ticks. A 16-bit up-counter runs freely and advances only on cycles where the prescale tick enable is high. A matching compare never clears it. When a trigger edge arrives, the block records the counter value as a timestamp. It then loads its two compare registers itself: one with the timestamp plus the delay, the other with the timestamp plus the delay plus the width. No software step is needed between the capture and the arming.

The output flip-flop toggles once on the first compare match and once on the second. After the second match it is disarmed until the next trigger. Each capture produces a one-cycle strobe. The closing match produces another one-cycle strobe, which an interrupt controller outside the block can take. Delay and width are written through a small write port, and software sets them before the trigger arrives.

Top module: `os_pulse_timer`

## Requirements
- R1: After a synchronous reset, `pulse_out`, `cap_irq` and `match_irq` are 0, the counter and `cap_val` are 0, and the delay and width registers both hold 1.
- R2: The counter increases by exactly one, modulo 2^16, on every clock edge where `tick_en` is high. It holds its value otherwise, and no compare match ever clears it.
- R3: `trig_in` passes through two synchronizer flops. When the block is idle, a rising edge on it stores the counter value of the capture cycle into `cap_val`, and `cap_irq` is high for exactly one cycle in the cycle after that capture.
- R4: At capture, compare 0 takes `cap + delay` and compare 1 takes `cap + delay + width`, both modulo 2^16.
- R5: `pulse_out` goes from 0 to 1 on the tick-enabled edge where the counter equals compare 0. It goes back to 0 on the tick-enabled edge where the counter equals compare 1, so it stays high for exactly `width` ticks.
- R6: `match_irq` is high for one cycle together with the fall of `pulse_out`. After that the block is disarmed: `pulse_out` stays 0 until a new trigger, even when the counter passes the old compare values again.
- R7: A trigger edge seen while a pulse is pending or high is ignored. No capture happens, `cap_irq` does not rise, and the pulse timing does not change.
- R8: A write with `wr_en`=1 stores `wr_data` in the delay register when `wr_sel`=0 and in the width register when `wr_sel`=1. A written value of 0 is stored as 1.
- R9: A pulse whose compare values wrap past 16'hFFFF keeps the programmed delay and width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled tick; the counter advances when high |
| trig_in | input | 1 | Asynchronous trigger input |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects delay, 1 selects width |
| wr_data | input | CNT_W | Value to write |
| pulse_out | output | 1 | One-shot pulse output |
| cap_irq | output | 1 | One-cycle capture strobe |
| match_irq | output | 1 | One-cycle strobe on the closing match |
| cap_val | output | CNT_W | Last captured counter value |

## Verification
The assertions check these properties on every cycle:
- The counter steps by one, and only on ticks.
- Each capture holds the counter value of the previous cycle.
- The compare registers hold the timestamp plus the offsets.
- A capture only comes out of the idle state.
- The output rises only on a tick where the counter equals compare 0.
- The output falls only together with the match strobe.
- The stored delay never reads zero.

Only the bench scenarios can show the complete pulse measured in ticks, which needs an independent counter model:
- the whole pulse under different prescale rates;
- the handling of zero writes;
- a pulse that crosses counter rollover;
- that a retrigger in the middle of a pulse leaves the timing unchanged;
- that the output stays quiet for a full counter period after disarming.

// File: rtl/os_timer_pkg.sv
package os_timer_pkg;

    localparam int unsigned TMR_W       = 16;
    localparam int unsigned SYNC_DEPTH  = 2;

    localparam logic SEL_DELAY = 1'b0;
    localparam logic SEL_WIDTH = 1'b1;

    typedef enum logic [1:0] {
        OS_IDLE  = 2'd0,
        OS_LEAD  = 2'd1,
        OS_TRAIL = 2'd2
    } os_state_e;

    typedef struct packed {
        logic      toggle;
        logic      cap_evt;
        logic      end_evt;
    } os_event_t;

endpackage

// File: rtl/os_trig_sync.sv
module os_trig_sync #(
    parameter int unsigned STAGES = os_timer_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    output logic trig_rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], trig_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign trig_rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/os_free_counter.sv
module os_free_counter #(
    parameter int unsigned CNT_W = os_timer_pkg::TMR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (tick_en) begin
            count <= count + CNT_W'(1);
        end
    end

    // R2: one step per tick, frozen otherwise
    a_r2_step_on_tick: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> count == CNT_W'($past(count) + CNT_W'(1)));
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(count));

endmodule

// File: rtl/os_param_regs.sv
module os_param_regs #(
    parameter int unsigned CNT_W = os_timer_pkg::TMR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] delay,
    output logic [CNT_W-1:0] width
);
    import os_timer_pkg::*;

    logic [CNT_W-1:0] wr_clean;

    assign wr_clean = (wr_data == '0) ? CNT_W'(1) : wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            delay <= CNT_W'(1);
            width <= CNT_W'(1);
        end else if (wr_en) begin
            if (wr_sel == SEL_DELAY) delay <= wr_clean;
            else                     width <= wr_clean;
        end
    end

    // R8: stored offsets are never zero
    a_r8_delay_nonzero: assert property (@(posedge clk) disable iff (rst)
        delay != '0);
    a_r8_width_nonzero: assert property (@(posedge clk) disable iff (rst)
        width != '0);

endmodule

// File: rtl/os_oneshot_ctrl.sv
module os_oneshot_ctrl #(
    parameter int unsigned CNT_W = os_timer_pkg::TMR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             trig_rise,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] delay,
    input  logic [CNT_W-1:0] width,
    output logic             pulse_out,
    output logic             cap_irq,
    output logic             match_irq,
    output logic [CNT_W-1:0] cap_val
);
    import os_timer_pkg::*;

    os_state_e        state_q, state_d;
    os_event_t        evt;
    logic [CNT_W-1:0] cmp0_q, cmp1_q;
    logic             hit0, hit1;

    assign hit0 = tick_en && (count == cmp0_q);
    assign hit1 = tick_en && (count == cmp1_q);

    always_comb begin
        state_d = state_q;
        evt     = '0;
        unique case (state_q)
            OS_IDLE: if (trig_rise) begin
                evt.cap_evt = 1'b1;
                state_d     = OS_LEAD;
            end
            OS_LEAD: if (hit0) begin
                evt.toggle = 1'b1;
                state_d    = OS_TRAIL;
            end
            OS_TRAIL: if (hit1) begin
                evt.toggle  = 1'b1;
                evt.end_evt = 1'b1;
                state_d     = OS_IDLE;
            end
            default: state_d = OS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= OS_IDLE;
            pulse_out <= 1'b0;
            cap_irq   <= 1'b0;
            match_irq <= 1'b0;
            cap_val   <= '0;
            cmp0_q    <= '0;
            cmp1_q    <= '0;
        end else begin
            state_q   <= state_d;
            cap_irq   <= evt.cap_evt;
            match_irq <= evt.end_evt;
            if (evt.toggle) pulse_out <= ~pulse_out;
            if (evt.cap_evt) begin
                cap_val <= count;
                cmp0_q  <= count + delay;
                cmp1_q  <= count + delay + width;
            end
        end
    end

    // R3: the capture holds the counter of the capture cycle
    a_r3_capture_value: assert property (@(posedge clk) disable iff (rst)
        cap_irq |-> cap_val == $past(count));
    // R4: compare registers are timestamp plus offsets
    a_r4_cmp0_offset: assert property (@(posedge clk) disable iff (rst)
        cap_irq |-> cmp0_q == CNT_W'(cap_val + $past(delay)));
    a_r4_cmp1_offset: assert property (@(posedge clk) disable iff (rst)
        cap_irq |-> cmp1_q == CNT_W'(cap_val + $past(delay) + $past(width)));
    // R7: captures only come from the idle state
    a_r7_capture_idle_only: assert property (@(posedge clk) disable iff (rst)
        cap_irq |-> $past(state_q) == OS_IDLE);
    // R5: the leading edge sits on a tick with a compare 0 match
    a_r5_rise_on_match: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_out) |-> ($past(tick_en) && $past(count) == $past(cmp0_q)));
    // R6: the trailing edge comes with the match strobe
    a_r6_fall_with_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_out) |-> match_irq);

endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer #(
    parameter int unsigned CNT_W = os_timer_pkg::TMR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             trig_in,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pulse_out,
    output logic             cap_irq,
    output logic             match_irq,
    output logic [CNT_W-1:0] cap_val
);

    logic             trig_rise;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] delay;
    logic [CNT_W-1:0] width;

    os_trig_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .trig_in   (trig_in),
        .trig_rise (trig_rise)
    );

    os_free_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .count   (count)
    );

    os_param_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .delay   (delay),
        .width   (width)
    );

    os_oneshot_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .trig_rise (trig_rise),
        .count     (count),
        .delay     (delay),
        .width     (width),
        .pulse_out (pulse_out),
        .cap_irq   (cap_irq),
        .match_irq (match_irq),
        .cap_val   (cap_val)
    );

endmodule

// File: tb/tb_os_pulse_timer.sv
module tb_os_pulse_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        trig_in = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        pulse_out, cap_irq, match_irq;
    logic [15:0] cap_val;

    int          checks = 0;
    int          errors = 0;
    int          tick_period = 1;
    logic [15:0] mcnt = '0;
    logic        last_tick = 1'b0;

    always #5 clk = ~clk;

    os_pulse_timer dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .trig_in(trig_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pulse_out(pulse_out), .cap_irq(cap_irq), .match_irq(match_irq),
        .cap_val(cap_val)
    );

    // tick source and independent counter model
    initial begin
        int phase;
        phase = 0;
        forever begin
            @(posedge clk);
            last_tick = tick_en && !rst;
            if (rst) mcnt = '0;
            else if (tick_en) mcnt = mcnt + 16'd1;
            #1;
            phase++;
            tick_en = (phase % tick_period) == 0;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_reg(logic sel, logic [15:0] val);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // one full pulse; checks capture, both edges and the end strobe
    task automatic run_pulse(string tag, logic [15:0] d, logic [15:0] w,
                             logic [15:0] exp_d, logic [15:0] exp_w, bit retrig);
        logic [15:0] c;
        int          n;
        bit          extra_cap;
        write_reg(1'b0, d);
        write_reg(1'b1, w);
        @(posedge clk); #1 trig_in = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!cap_irq && n < 50);
        chk({tag, " R3 capture strobe"}, cap_irq, 1);
        c = mcnt - 16'(last_tick);
        chk({tag, " R2 captured counter value"}, cap_val, c);
        @(posedge clk); #1 trig_in = 1'b0;
        n = 0;
        while (!pulse_out && n < 100000) begin @(negedge clk); n++; end
        chk({tag, " R5 leading edge tick"}, mcnt, 16'(c + exp_d + 16'd1));
        extra_cap = 1'b0;
        if (retrig) begin
            @(posedge clk); #1 trig_in = 1'b1;
            repeat (4) @(posedge clk);
            #1 trig_in = 1'b0;
        end
        n = 0;
        while (pulse_out && n < 100000) begin
            @(negedge clk); n++;
            if (cap_irq) extra_cap = 1'b1;
        end
        chk({tag, " R6 match strobe with fall"}, match_irq, 1);
        chk({tag, " R5 trailing edge tick"}, mcnt, 16'(c + exp_d + exp_w + 16'd1));
        if (retrig) chk({tag, " R7 retrigger ignored"}, extra_cap, 0);
        @(negedge clk);
        chk({tag, " R6 strobe one cycle"}, match_irq, 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1 pulse low", pulse_out, 0);
        chk("R1 cap strobe low", cap_irq, 0);
        chk("R1 match strobe low", match_irq, 0);
        chk("R1 capture zero", cap_val, 0);
    endtask

    task automatic test_idle_full_wrap();
        bit bad;
        bad = 1'b0;
        tick_period = 1;
        repeat (65600) begin
            @(negedge clk);
            if (pulse_out || match_irq) bad = 1'b1;
        end
        chk("R6 disarmed over full counter period", bad, 0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        test_reset();
        tick_period = 1;
        run_pulse("basic", 16'd5, 16'd3, 16'd5, 16'd3, 1'b0);
        tick_period = 3;
        run_pulse("prescaled R4", 16'd4, 16'd2, 16'd4, 16'd2, 1'b0);
        run_pulse("retrig", 16'd3, 16'd20, 16'd3, 16'd20, 1'b1);
        tick_period = 2;
        run_pulse("zero R8", 16'd0, 16'd0, 16'd1, 16'd1, 1'b0);
        tick_period = 1;
        while (mcnt != 16'hFFF0) @(negedge clk);
        run_pulse("rollover R9", 16'd20, 16'd10, 16'd20, 16'd10, 1'b0);
        test_idle_full_wrap();
        summary();
        $finish;
    end

endmodule